// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block runs on the host side of an asynchronous DRAM with a multiplexed address bus and keeps the array alive. After reset it waits out a power-up pause with every strobe inactive. It then fires a fixed burst of wake-up refresh cycles on its own and raises `ready` so the access controller may start work. From then on a divider marks out one owed refresh per interval. Each owed refresh is requested from the access controller. The refresh strobes are driven only once `ref_gnt` shows that the access controller has released the bus with its RAS high.

A parameter selects one of two refresh styles. In the CAS-before-RAS style, CAS drops ahead of RAS and the DRAM supplies the row itself. In the RAS-only style, CAS stays high and the block places a 10-bit row from its own wrapping counter on the address lines. Write-enable is held high at all times, because a CAS-before-RAS cycle with write-enable low would put the part into a test mode. Only refresh cycles with write-enable high bring the part out of that mode, so the wake-up burst also clears it.

Owed refreshes that cannot be served pile up in a backlog. If the backlog would exceed its limit, the retention deadline is taken as missed. The block then pulses `overdue`, withdraws `ready` and repeats the whole wake-up burst. All durations are parameters counted in clock cycles.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held and just after it, `ras_n`, `cas_n` and `we_n` are 1 and `ready`, `ref_req`, `overdue` and `addr_en` are 0.
- R2: Neither `ras_n` nor `cas_n` goes low during the first PAUSE_CYC clock cycles after reset is released.
- R3: After the pause, exactly WAKE_CNT refresh cycles (RAS low pulses) are issued without `ref_gnt` and with `ref_req` low, and `ready` rises when the last one ends.
- R4: With CBR_MODE=1, `cas_n` is low for exactly CAS_SETUP_CYC cycles before `ras_n` falls and stays low while `ras_n` is low.
- R5: With CBR_MODE=0, `cas_n` stays 1 throughout, and `addr_en` is 1 while `ras_n` is low.
- R6: Every RAS low pulse lasts exactly RAS_LOW_CYC cycles, and RAS stays high at least RAS_PRE_CYC cycles between pulses.
- R7: Once `ready` is 1, one refresh is owed every INTERVAL_CYC cycles. With `ref_gnt` held 1, RAS falls once per interval, and `ref_req` is 1 whenever RAS is low during this phase.
- R8: While `ready` is 1 and `ref_gnt` is 0, no strobe goes low. Owed refreshes are kept, and once `ref_gnt` returns they are served back to back.
- R9: When a new owed refresh would push the backlog above BACKLOG_MAX, `overdue` is 1 for one cycle, `ready` falls at the same time, and a fresh burst of WAKE_CNT refresh cycles runs before `ready` rises again.
- R10: With CBR_MODE=0, `row_addr` at each RAS fall takes the values 0, 1, 2 and so on across all refresh cycles, wake-up cycles included, and wraps from 1023 to 0.
- R11: `we_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller has RAS high and yields the bus |
| ref_req | output | 1 | Refresh owed or in progress; access controller must yield |
| ready | output | 1 | Initialisation done; ordinary accesses allowed |
| overdue | output | 1 | One-cycle pulse: backlog limit exceeded, re-wake started |
| ras_n | output | 1 | Row strobe for refresh cycles, active low |
| cas_n | output | 1 | Column strobe for refresh cycles, active low |
| we_n | output | 1 | Write-enable, held high |
| addr_en | output | 1 | Drive `row_addr` onto the address bus (RAS-only style) |
| row_addr | output | ROW_BITS | Refresh row for the RAS-only style |

## Verification
The hardest state to reach is the missed deadline. The access controller has to withhold its grant for longer than BACKLOG_MAX intervals, and the bench must show that no strobe moved in that time and that the pulse came in the right interval. The stimulus drops `ref_gnt` just after a refresh pulse ends, so the backlog starts at zero, and keeps it low until `overdue` appears. The bench then counts the re-wake pulses while the grant is still withheld. A shorter withholding that stays under the limit checks the back-to-back catch-up. A long granted run pushes the RAS-only row counter past its wrap.

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer #(
  parameter bit CBR_MODE      = 1'b1,
  parameter int ROW_BITS      = 10,
  parameter int PAUSE_CYC     = 12500,
  parameter int WAKE_CNT      = 8,
  parameter int INTERVAL_CYC  = 1950,
  parameter int BACKLOG_MAX   = 8,
  parameter int CAS_SETUP_CYC = 2,
  parameter int RAS_LOW_CYC   = 6,
  parameter int RAS_PRE_CYC   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                ready,
  output logic                overdue,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int TMAX = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DMX1 = (CAS_SETUP_CYC > RAS_LOW_CYC) ? CAS_SETUP_CYC : RAS_LOW_CYC;
  localparam int DMAX = (DMX1 > RAS_PRE_CYC) ? DMX1 : RAS_PRE_CYC;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int WW   = $clog2(WAKE_CNT + 1);
  localparam int BW   = $clog2(BACKLOG_MAX + 2);

  typedef enum logic [1:0] {PH_PAUSE, PH_WAKE, PH_RUN} phase_t;
  typedef enum logic [1:0] {CY_IDLE, CY_SETUP, CY_LOW, CY_PRE} cyc_t;

  phase_t              phase;
  cyc_t                cyc;
  logic [TW-1:0]       tmr;
  logic [DW-1:0]       dcnt;
  logic [WW-1:0]       wk;
  logic [BW-1:0]       backlog;
  logic [ROW_BITS-1:0] row;
  logic [BW:0]         bl_next;

  wire tick     = (phase == PH_RUN) && (tmr == '0);
  wire run_go   = (phase == PH_RUN) && (backlog != '0) && ref_gnt;
  wire start    = (cyc == CY_IDLE) && ((phase == PH_WAKE) || run_go);
  wire take     = start && (phase == PH_RUN);
  wire cyc_done = (cyc == CY_PRE) && (dcnt == '0);

  assign bl_next = {1'b0, backlog} + (BW+1)'(tick) - (BW+1)'(take);
  wire over = bl_next > (BW+1)'(BACKLOG_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_PAUSE;
      cyc     <= CY_IDLE;
      tmr     <= TW'(PAUSE_CYC - 1);
      dcnt    <= '0;
      wk      <= '0;
      backlog <= '0;
      row     <= '0;
      overdue <= 1'b0;
    end else begin
      overdue <= 1'b0;
      case (cyc)
        CY_IDLE:  if (start) begin cyc <= CY_SETUP; dcnt <= DW'(CAS_SETUP_CYC - 1); end
        CY_SETUP: if (dcnt == '0) begin cyc <= CY_LOW; dcnt <= DW'(RAS_LOW_CYC - 1); end
                  else dcnt <= dcnt - 1'b1;
        CY_LOW:   if (dcnt == '0) begin
                    cyc  <= CY_PRE;
                    dcnt <= DW'(RAS_PRE_CYC - 1);
                    if (!CBR_MODE) row <= row + 1'b1;
                  end else dcnt <= dcnt - 1'b1;
        default:  if (dcnt == '0) cyc <= CY_IDLE;
                  else dcnt <= dcnt - 1'b1;
      endcase
      case (phase)
        PH_PAUSE: if (tmr == '0) phase <= PH_WAKE;
                  else tmr <= tmr - 1'b1;
        PH_WAKE:  if (cyc_done) begin
                    if (wk == WW'(WAKE_CNT - 1)) begin
                      phase   <= PH_RUN;
                      wk      <= '0;
                      backlog <= '0;
                      tmr     <= TW'(INTERVAL_CYC - 1);
                    end else wk <= wk + 1'b1;
                  end
        default: begin
          tmr <= tick ? TW'(INTERVAL_CYC - 1) : tmr - 1'b1;
          if (over) begin
            overdue <= 1'b1;
            phase   <= PH_WAKE;
            wk      <= '0;
            backlog <= '0;
          end else backlog <= bl_next[BW-1:0];
        end
      endcase
    end
  end

  assign ras_n    = (cyc != CY_LOW);
  assign cas_n    = !(CBR_MODE && ((cyc == CY_SETUP) || (cyc == CY_LOW)));
  assign we_n     = 1'b1;
  assign addr_en  = !CBR_MODE && ((cyc == CY_SETUP) || (cyc == CY_LOW));
  assign row_addr = row;
  assign ready    = (phase == PH_RUN);
  assign ref_req  = ready && ((backlog != '0) || (cyc != CY_IDLE));
endmodule

// File: rtl/dram_refresh_sequencer_chk.sv
module dram_refresh_sequencer_chk #(
  parameter bit CBR_MODE    = 1'b1,
  parameter int RAS_LOW_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ref_req,
  input logic ready,
  input logic overdue,
  input logic ras_n,
  input logic cas_n,
  input logic addr_en
);
  logic [15:0] lowrun;
  always_ff @(posedge clk) begin
    if (!rst_n) lowrun <= '0;
    else if (!ras_n) lowrun <= lowrun + 1'b1;
    else lowrun <= '0;
  end

  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (CBR_MODE && $fell(ras_n)) |-> (!cas_n && !$past(cas_n)));

  assert_rasonly_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!CBR_MODE && !ras_n) |-> (cas_n && addr_en));

  assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lowrun == 16'(RAS_LOW_CYC)));

  assert_quiet_without_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ref_req) |-> (ras_n && cas_n));

  assert_overdue_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> !ready);
endmodule

bind dram_refresh_sequencer dram_refresh_sequencer_chk #(
  .CBR_MODE(CBR_MODE), .RAS_LOW_CYC(RAS_LOW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ready(ready),
  .overdue(overdue), .ras_n(ras_n), .cas_n(cas_n), .addr_en(addr_en)
);

// File: tb/dram_refresh_sequencer_tb.sv
module dram_refresh_sequencer_tb;
  localparam int PAUSE = 200, WAKE = 8, INTV = 60, BMAX = 3;
  localparam int SETUP = 2, LOW = 4, PRE = 3;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  always #4 clk = ~clk;

  logic req_a, rdy_a, ovd_a, ras_a, cas_a, we_a, ae_a;
  logic req_b, rdy_b, ovd_b, ras_b, cas_b, we_b, ae_b;
  logic [9:0] row_a, row_b;

  dram_refresh_sequencer #(.CBR_MODE(1'b1), .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE),
    .INTERVAL_CYC(INTV), .BACKLOG_MAX(BMAX), .CAS_SETUP_CYC(SETUP),
    .RAS_LOW_CYC(LOW), .RAS_PRE_CYC(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req_a), .ready(rdy_a),
    .overdue(ovd_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a),
    .addr_en(ae_a), .row_addr(row_a));

  dram_refresh_sequencer #(.CBR_MODE(1'b0), .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE),
    .INTERVAL_CYC(INTV), .BACKLOG_MAX(BMAX), .CAS_SETUP_CYC(SETUP),
    .RAS_LOW_CYC(LOW), .RAS_PRE_CYC(PRE)) u_dut_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req_b), .ready(rdy_b),
    .overdue(ovd_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b),
    .addr_en(ae_b), .row_addr(row_b));

  int n_run = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0, first_strobe = -1;
  int falls_a = 0, falls_b = 0, rises_a = 0, last_fall = 0, last_gap = 0;
  int caslow = 0, lowrun = 0, highrun = 1000;
  bit prev_ras_a = 1, prev_ras_b = 1, we_low = 0, req_early = 0, ovd_seen = 0;
  int exp_rows[$];
  int next_row = 0;

  task automatic push_expected();
    exp_rows.push_back(next_row);
    next_row = (next_row + 1) % 1024;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_a || !we_b) we_low = 1;
      if ((req_a && !rdy_a) || (req_b && !rdy_b)) req_early = 1;
      if (ovd_a) ovd_seen = 1;
      if (first_strobe < 0 && (!ras_a || !cas_a || !ras_b || !cas_b)) first_strobe = cyc;
      // CBR instance timing
      if (prev_ras_a && !ras_a) begin
        falls_a++;
        chk(!cas_a && caslow == SETUP, "R4 cas lead", caslow, SETUP);
        chk(highrun >= PRE, "R6 precharge", highrun, PRE);
        if (rdy_a) chk(req_a, "R7 req held", req_a, 1);
        last_gap = cyc - last_fall;
        last_fall = cyc;
      end
      if (!prev_ras_a && ras_a) begin
        rises_a++;
        chk(lowrun == LOW, "R6 ras width", lowrun, LOW);
      end
      if (!ras_a) chk(!cas_a, "R4 cas held", cas_a, 0);
      caslow  = cas_a ? 0 : caslow + 1;
      lowrun  = ras_a ? 0 : lowrun + 1;
      highrun = ras_a ? highrun + 1 : 0;
      prev_ras_a = ras_a;
      // RAS-only instance scoreboard
      while (exp_rows.size() < 4) push_expected();
      if (!ras_b) chk(cas_b && ae_b, "R5 cas high addr on", {cas_b, ae_b}, 3);
      if (prev_ras_b && !ras_b) begin
        int e;
        falls_b++;
        e = exp_rows.pop_front();
        chk(int'(row_b) == e, "R10 row order", row_b, e);
      end
      prev_ras_b = ras_b;
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int f0, t0;
    repeat (3) @(negedge clk);
    chk(ras_a && cas_a && we_a && !rdy_a && !req_a && !ovd_a && !ae_a,
        "R1 reset outputs", {ras_a, cas_a, we_a, rdy_a, req_a, ovd_a, ae_a}, 7'b1110000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(ras_a && cas_a && !rdy_a && !req_a, "R1 after release", {ras_a, cas_a, rdy_a, req_a}, 4'b1100);
    while (!rdy_a) @(negedge clk);
    chk(first_strobe >= PAUSE, "R2 pause", first_strobe, PAUSE);
    chk(falls_a == WAKE, "R3 wake count cbr", falls_a, WAKE);
    chk(falls_b == WAKE, "R3 wake count ras-only", falls_b, WAKE);
    chk(!req_early, "R3 no req before ready", req_early, 0);
    gnt = 1'b1;
    // R7 steady interval
    f0 = falls_a;
    while (falls_a < f0 + 3) @(negedge clk);
    chk(last_gap == INTV, "R7 interval", last_gap, INTV);
    f0 = falls_a;
    while (falls_a < f0 + 1) @(negedge clk);
    chk(last_gap == INTV, "R7 interval again", last_gap, INTV);
    // R8 catch-up
    f0 = rises_a;
    while (rises_a == f0) @(negedge clk);
    gnt = 1'b0;
    f0 = falls_a;
    repeat (140) @(negedge clk);
    chk(falls_a == f0, "R8 held off", falls_a, f0);
    chk(rdy_a && req_a, "R8 req pending", {rdy_a, req_a}, 3);
    gnt = 1'b1;
    repeat (25) @(negedge clk);
    chk(falls_a == f0 + 2, "R8 back to back", falls_a, f0 + 2);
    // R9 overdue
    f0 = rises_a;
    while (rises_a == f0) @(negedge clk);
    gnt = 1'b0;
    f0 = falls_a; t0 = cyc; ovd_seen = 0;
    while (!ovd_a && cyc < t0 + 6 * INTV) @(negedge clk);
    chk(ovd_a, "R9 overdue pulse", ovd_a, 1);
    chk(!rdy_a, "R9 ready dropped", rdy_a, 0);
    chk(cyc - t0 >= BMAX * INTV && cyc - t0 <= (BMAX + 1) * INTV + 2,
        "R9 overdue timing", cyc - t0, (BMAX + 1) * INTV);
    chk(falls_a == f0, "R8 no strobe while ungranted", falls_a, f0);
    @(negedge clk);
    chk(!ovd_a, "R9 one cycle pulse", ovd_a, 0);
    while (!rdy_a) @(negedge clk);
    chk(falls_a == f0 + WAKE, "R9 rewake count", falls_a - f0, WAKE);
    gnt = 1'b1;
    // R10 wrap of row counter
    while (falls_b < 1030) @(negedge clk);
    chk(falls_b > 1024, "R10 wrap reached", falls_b, 1025);
    chk(!we_low, "R11 we high", we_low, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule